// File: doc/BRIEF.md
# Serial ADC Sequencing Master

This block runs a 12-bit successive-approximation converter from the system clock over four wires. The wires are a conversion-start strobe, a serial clock, a configuration data line going out and a result data line coming in. The host presents a 6-bit configuration word with a one-cycle start request. The block raises the start strobe and holds it high for the worst-case conversion time. It then lowers the strobe, which lets the converter drive its output. After that it runs one frame of exactly twelve serial clock pulses. Each pulse sends one configuration bit and receives one result bit.

The converter takes a configuration word in the frame that follows the previous conversion. The word shifted out in a frame therefore sets up the next conversion. The result arrives MSB first and is presented on a parallel port with a one-cycle valid strobe. If the last word sent had its sleep bit set, the converter powers down while the strobe is high. In that case the block waits a wake-up interval after lowering the strobe and only then clocks the frame. The block also enforces a minimum spacing between conversion starts and a minimum acquisition window after the sixth serial clock rise. All times are counted in system clock cycles and set by parameters.

Top module: `sar_link_ctrl`

## Requirements
- R1: While `ready` is high, a `start` pulse is accepted. In the next cycle `adc_convst` is high, `busy` is high and `ready` is low.
- R2: A `start` that arrives while `ready` is low is ignored. It produces no new rise on `adc_convst` and does not replace the configuration word being sent.
- R3: `adc_convst` stays high for at least `CONV_CYC` cycles after each rise. It never falls earlier.
- R4: Each conversion is followed by exactly 12 pulses on `adc_sck`, each phase `SCK_HALF` cycles long. `adc_sck` is low whenever `adc_convst` is high and between frames.
- R5: `adc_sdi` sends `cfg_in` bit 5 first and bit 0 last, over the first six rising edges of `adc_sck`. Bit 5 selects single-ended or differential input, bit 4 is odd/sign, bits 3:2 are the channel address, bit 1 selects unipolar coding and bit 0 is the sleep request. The line is low for the remaining six pulses and changes only while `adc_sck` is low.
- R6: `adc_sdo` is sampled on each rising edge of `adc_sck`, and the first bit sampled becomes `result[11]`. After the 12th sample, `result` holds the word and `result_vld` is high for exactly one cycle.
- R7: `busy` rises with `adc_convst` and falls in the cycle in which `result_vld` rises.
- R8: Two rises of `adc_convst` are at least `CYC_MIN` cycles apart. At least `ACQ_CYC` cycles pass between the 6th `adc_sck` rise of a frame and the next rise of `adc_convst`.
- R9: If bit 0 of the word sent in the previous frame was 1, at least `WAKE_CYC` cycles pass from the fall of `adc_convst` to the first `adc_sck` rise. Otherwise the first rise comes `SCK_HALF` cycles after the fall.
- R10: After reset, `adc_convst`, `adc_sck`, `adc_sdi`, `busy`, `result_vld` and `result` are all zero, and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion |
| cfg_in | input | 6 | Configuration word sent in this conversion's readout frame |
| ready | output | 1 | Block is idle and will accept `start` |
| busy | output | 1 | Conversion or readout in progress |
| result | output | 12 | Last captured conversion word |
| result_vld | output | 1 | One-cycle strobe: `result` has been updated |
| adc_convst | output | 1 | Conversion start strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Configuration data to the converter |
| adc_sdo | input | 1 | Result data from the converter |

## Verification
The bench builds the block with `CONV_CYC`=80 and `SCK_HALF`=2, which gives a 1.6 µs hold and a 12.5 MHz serial clock at 50 MHz. It keeps `ACQ_CYC` at 12 and raises `CYC_MIN` to 160. With that spacing the hold state really limits back-to-back conversions, so the bench can measure the exact gap between starts. `WAKE_CYC` is cut to 400 so that the sleep/wake path, together with the short frame that follows it, fits in a short run. The behavioural converter drives its output line high-impedance outside the frame. A sample taken too early or too late therefore shows up as a wrong result word.

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl #(
  parameter int CONV_CYC = 80,
  parameter int SCK_HALF = 2,
  parameter int ACQ_CYC  = 12,
  parameter int CYC_MIN  = 100,
  parameter int WAKE_CYC = 10_000_000,
  parameter int CFG_W    = 6,
  parameter int RES_W    = 12
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             ready,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             result_vld,
  output logic             adc_convst,
  output logic             adc_sck,
  output logic             adc_sdi,
  input  logic             adc_sdo
);
  localparam int TMAX = (WAKE_CYC > CONV_CYC) ? WAKE_CYC : CONV_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(SCK_HALF + 1);
  localparam int BW   = $clog2(RES_W + 1);
  localparam int GW   = $clog2(CYC_MIN + 1);
  localparam int AW   = $clog2(ACQ_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_WAKE, S_SHIFT, S_HOLD} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [PW-1:0]    ph;
  logic [BW-1:0]    nb;
  logic [GW-1:0]    since;
  logic [AW-1:0]    acq;
  logic [CFG_W-1:0] tx;
  logic [RES_W-2:0] rx;
  logic             slp_q;

  assign ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tmr        <= '0;
      ph         <= '0;
      nb         <= '0;
      since      <= GW'(CYC_MIN);
      acq        <= AW'(ACQ_CYC);
      tx         <= '0;
      rx         <= '0;
      slp_q      <= 1'b0;
      busy       <= 1'b0;
      result     <= '0;
      result_vld <= 1'b0;
      adc_convst <= 1'b0;
      adc_sck    <= 1'b0;
      adc_sdi    <= 1'b0;
    end else begin
      result_vld <= 1'b0;
      if (since != GW'(CYC_MIN)) since <= since + 1'b1;
      if (acq != AW'(ACQ_CYC)) acq <= acq + 1'b1;

      case (st)
        S_IDLE: if (start) begin
          st         <= S_CONV;
          adc_convst <= 1'b1;
          busy       <= 1'b1;
          tmr        <= '0;
          ph         <= '0;
          nb         <= '0;
          tx         <= cfg_in;
          since      <= '0;
        end

        S_CONV: if (tmr == TW'(CONV_CYC - 1)) begin
          adc_convst <= 1'b0;
          tmr        <= '0;
          if (slp_q) st <= S_WAKE;
          else begin
            st      <= S_SHIFT;
            adc_sdi <= tx[CFG_W-1];
          end
        end else tmr <= tmr + 1'b1;

        S_WAKE: if (tmr == TW'(WAKE_CYC - 1)) begin
          st      <= S_SHIFT;
          adc_sdi <= tx[CFG_W-1];
        end else tmr <= tmr + 1'b1;

        S_SHIFT: if (ph == PW'(SCK_HALF - 1)) begin
          ph <= '0;
          if (!adc_sck) begin
            adc_sck <= 1'b1;
            rx      <= {rx[RES_W-3:0], adc_sdo};
            if (nb == BW'(CFG_W - 1)) begin
              slp_q <= adc_sdi;
              acq   <= '0;
            end
            if (nb == BW'(RES_W - 1)) begin
              result     <= {rx, adc_sdo};
              result_vld <= 1'b1;
              busy       <= 1'b0;
            end
          end else begin
            adc_sck <= 1'b0;
            tx      <= {tx[CFG_W-2:0], 1'b0};
            adc_sdi <= tx[CFG_W-2];
            nb      <= nb + 1'b1;
            if (nb == BW'(RES_W - 1)) st <= S_HOLD;
          end
        end else ph <= ph + 1'b1;

        S_HOLD: if (since >= GW'(CYC_MIN - 1) && acq == AW'(ACQ_CYC)) st <= S_IDLE;

        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_link_ctrl_chk.sv
module sar_link_ctrl_chk #(
  parameter int CONV_CYC = 80,
  parameter int CYC_MIN  = 100
)(
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ready,
  input logic busy,
  input logic result_vld,
  input logic adc_convst,
  input logic adc_sck,
  input logic adc_sdi
);
  localparam int HW = $clog2(CONV_CYC + 1);
  localparam int GW = $clog2(CYC_MIN + 1);

  logic [HW-1:0] hi_cnt;
  logic [GW-1:0] gap;
  logic          cv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      gap    <= GW'(CYC_MIN);
      cv_d   <= 1'b0;
    end else begin
      cv_d <= adc_convst;
      if (!adc_convst) hi_cnt <= '0;
      else if (hi_cnt != HW'(CONV_CYC)) hi_cnt <= hi_cnt + 1'b1;
      if (adc_convst && !cv_d) gap <= GW'(1);
      else if (gap != GW'(CYC_MIN)) gap <= gap + 1'b1;
    end
  end

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start |=> adc_convst && busy && !ready);
  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !ready |=> !$rose(adc_convst));
  // R3
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_convst) |-> hi_cnt >= HW'(CONV_CYC));
  // R4
  sck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_convst |-> !adc_sck);
  // R5
  sdi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sck && $past(adc_sck) |-> $stable(adc_sdi));
  // R6
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);
  // R7
  vld_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_vld) |-> $fell(busy));
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_convst) |-> busy);
  // R8
  start_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_convst) |-> gap >= GW'(CYC_MIN));
endmodule

bind sar_link_ctrl sar_link_ctrl_chk #(.CONV_CYC(CONV_CYC), .CYC_MIN(CYC_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .busy(busy),
  .result_vld(result_vld), .adc_convst(adc_convst), .adc_sck(adc_sck), .adc_sdi(adc_sdi)
);

// File: tb/sar_link_ctrl_bench.sv
`timescale 1ns/1ps
module sar_link_ctrl_bench;
  localparam int CONV = 80;
  localparam int HALF = 2;
  localparam int ACQ  = 12;
  localparam int CMIN = 160;
  localparam int WAKE = 400;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] cfg_in = '0;
  logic ready, busy, result_vld, adc_convst, adc_sck, adc_sdi, adc_sdo;
  logic [11:0] result;

  always #10 clk = ~clk;

  sar_link_ctrl #(.CONV_CYC(CONV), .SCK_HALF(HALF), .ACQ_CYC(ACQ), .CYC_MIN(CMIN),
                  .WAKE_CYC(WAKE)) u_sar_link_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in), .ready(ready), .busy(busy),
    .result(result), .result_vld(result_vld), .adc_convst(adc_convst), .adc_sck(adc_sck),
    .adc_sdi(adc_sdi), .adc_sdo(adc_sdo));

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;

  // behavioural converter
  logic [11:0] code_next = '0, m_data = '0;
  logic [5:0]  m_din = '0, din_seen = '0;
  logic        sdo_en = 1'b0, m_slp_last = 1'b0, m_sleeping = 1'b0;
  int bitp = 11, rises = 0, nrise = 0, rise_t = 0, fall_t = 0, sixth_t = -1000;
  int first_gap = 0, early_fall = 0, min_gap = 1000000, min_acq = 1000000;

  assign adc_sdo = sdo_en ? m_data[bitp] : 1'bz;

  always @(posedge adc_convst) begin
    if (nrise > 0 && cyc - rise_t < min_gap) min_gap = cyc - rise_t;
    if (nrise > 0 && cyc - sixth_t < min_acq) min_acq = cyc - sixth_t;
    rise_t = cyc; nrise++; m_data = code_next; sdo_en = 1'b0;
  end
  always @(negedge adc_convst) begin
    if (cyc - rise_t < CONV) early_fall++;
    fall_t = cyc; sdo_en = 1'b1; bitp = 11; rises = 0; m_sleeping = m_slp_last;
  end
  always @(posedge adc_sck) begin
    if (rises == 0) first_gap = cyc - fall_t;
    if (rises < 6) m_din = {m_din[4:0], adc_sdi};
    rises++;
    if (rises == 6) begin sixth_t = cyc; din_seen = m_din; m_slp_last = adc_sdi; end
  end
  always @(negedge adc_sck) begin
    if (bitp > 0) bitp--; else sdo_en = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic run_conv(input logic [5:0] cfg, input logic [11:0] code, output logic [11:0] got);
    code_next = code;
    do @(negedge clk); while (!ready);
    start = 1'b1; cfg_in = cfg;
    @(negedge clk);
    start = 1'b0;
    chk(busy && adc_convst && !ready, "R1 accept", {busy, adc_convst, ready}, 3'b110);
    do @(negedge clk); while (!result_vld);
    got = result;
    chk(!busy, "R7 busy falls with valid", busy, 0);
    @(negedge clk);
    chk(!result_vld, "R6 valid one cycle", result_vld, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!adc_convst && !adc_sck && !adc_sdi, "R10 link idle", {adc_convst, adc_sck, adc_sdi}, 0);
    chk(!busy && !result_vld && ready, "R10 status", {busy, result_vld, ready}, 3'b001);
    chk(result == 12'h000, "R10 result", result, 0);
  endtask

  task automatic t_basic();
    logic [11:0] got;
    run_conv(6'b101101, 12'hA5C, got);
    chk(got == 12'hA5C, "R6 result word", got, 12'hA5C);
    chk(din_seen == 6'b101101, "R5 config bits", din_seen, 6'b101101);
    chk(first_gap == HALF, "R9 no wake wait", first_gap, HALF);
    do @(negedge clk); while (!ready);
    chk(rises == 12, "R4 pulse count", rises, 12);
    chk(!adc_sck, "R4 sck idle low", adc_sck, 0);
  endtask

  task automatic t_patterns();
    logic [11:0] codes [5] = '{12'h000, 12'hFFF, 12'h801, 12'h7FE, 12'h3C3};
    logic [5:0]  cfgs  [5] = '{6'b111110, 6'b000000, 6'b010100, 6'b101010, 6'b100110};
    for (int i = 0; i < 5; i++) begin
      logic [11:0] got;
      run_conv(cfgs[i], codes[i], got);
      chk(got == codes[i], "R6 pattern word", got, codes[i]);
      chk(din_seen == cfgs[i], "R5 pattern config", din_seen, cfgs[i]);
    end
  endtask

  task automatic t_ignore();
    int n0;
    logic [11:0] got;
    n0 = nrise;
    code_next = 12'h5A3;
    do @(negedge clk); while (!ready);
    start = 1'b1; cfg_in = 6'b110100;
    @(negedge clk);
    cfg_in = 6'b001000;
    repeat (30) @(negedge clk);
    start = 1'b0;
    do @(negedge clk); while (!result_vld);
    got = result;
    chk(nrise == n0 + 1, "R2 one conversion", nrise - n0, 1);
    chk(din_seen == 6'b110100, "R2 config kept", din_seen, 6'b110100);
    chk(got == 12'h5A3, "R6 word after ignored start", got, 12'h5A3);
  endtask

  task automatic t_backtoback();
    int n0;
    n0 = nrise;
    min_gap = 1000000; min_acq = 1000000;
    code_next = 12'h9C6;
    do @(negedge clk); while (!ready);
    start = 1'b1; cfg_in = 6'b000100;
    do @(negedge clk); while (nrise < n0 + 3);
    start = 1'b0;
    do @(negedge clk); while (!ready);
    chk(min_gap >= CMIN && min_gap <= CMIN + 2, "R8 start spacing", min_gap, CMIN + 1);
    chk(min_acq >= ACQ, "R8 acquisition window", min_acq, ACQ);
    chk(result == 12'h9C6, "R6 back-to-back word", result, 12'h9C6);
  endtask

  task automatic t_sleep();
    logic [11:0] got;
    run_conv(6'b000011, 12'h123, got);
    chk(first_gap == HALF, "R9 before sleep", first_gap, HALF);
    run_conv(6'b000010, 12'hE0F, got);
    chk(m_sleeping && first_gap >= WAKE, "R9 wake wait", first_gap, WAKE + HALF);
    chk(got == 12'hE0F, "R6 word after wake", got, 12'hE0F);
    run_conv(6'b000010, 12'h0F0, got);
    chk(first_gap == HALF, "R9 awake again", first_gap, HALF);
    chk(early_fall == 0, "R3 convst held through conversion", early_fall, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_patterns();
    t_ignore();
    t_backtoback();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule